// File: doc/BRIEF.md
# Command Slot Execution Dispatcher

This block feeds one command at a time from a queue of pending slot numbers to the link protocol engine. A port has 31 command slots, numbered 0 to 30. There are two ways to submit a slot number, and both go into one shared 5-bit execution queue:

- The host can write a slot number straight to the block. In this direct method the host has already put the request block into slot RAM.
- The indirect fetch engine can push a slot number once it has copied the request block into slot RAM.

Either way, an accepted slot number marks that slot active in a 31-bit slot status vector. The host polls this vector to learn which commands have finished.

When the dispatcher is idle, the serial link is not busy and the queue holds an entry, the dispatcher pops the oldest slot number. It then pulses a dispatch strobe carrying the slot number and the slot's RAM base address, which is the slot number times 128. It waits until the protocol engine reports done or error. It then clears the slot's active bit and sets the completion flag or the error flag in a two-bit interrupt status register. The host clears these flags by writing ones. The interrupt output is the OR of the status flags, each gated by an enable bit.

Top module: `slot_dispatch`

## Requirements
- R1: After reset the queue is empty, every bit of `slot_active` is 0, `irq_status` is 0, `disp_valid` is 0 and `irq` is 0.
- R2: A direct write (`host_slot_we`) of slot s in 0..30, when s is not active, sets `slot_active[s]` at the next clock edge and appends s to the queue.
- R3: A fetch-path push (`fetch_slot_we`) of slot s behaves the same as R2. When both paths submit distinct valid slots in one cycle, the direct slot is queued ahead of the fetched one.
- R4: A submission is ignored, with no status change and no queue entry, in three cases: the slot number is 31, the slot is already active, or it is the fetch-path copy of the slot the direct path submits in the same cycle.
- R5: A dispatch happens only when the dispatcher is idle, `link_busy` is 0 and the queue is not empty. `disp_valid` is then a one-cycle pulse one clock after that condition holds, and slots leave in arrival order.
- R6: While `disp_valid` is 1, `disp_addr` equals `disp_slot` × 128.
- R7: Only one command is outstanding. No dispatch occurs between a dispatch and the `cmd_done`/`cmd_err` that ends it. The next dispatch can occur at the earliest one clock after that end.
- R8: `cmd_done` or `cmd_err` while a command is outstanding clears the executing slot's active bit. It also sets `irq_status[0]` (completion) for done alone, or `irq_status[1]` (error) whenever `cmd_err` is 1. Both inputs are ignored while idle.
- R9: Writing `irq_clr_we` with `irq_clr_mask` bit i = 1 clears `irq_status[i]`. A flag set in the same cycle stays set.
- R10: `irq` equals the OR over i of `irq_status[i] & irq_enable[i]`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_slot_we | input | 1 | Direct slot submission strobe |
| host_slot_num | input | 5 | Directly submitted slot number |
| fetch_slot_we | input | 1 | Fetch-engine slot push strobe |
| fetch_slot_num | input | 5 | Slot number from fetch engine |
| link_busy | input | 1 | Serial link busy, blocks dispatch |
| disp_valid | output | 1 | One-cycle dispatch strobe |
| disp_slot | output | 5 | Slot being executed |
| disp_addr | output | 12 | Slot RAM base address |
| cmd_done | input | 1 | Protocol engine reports success |
| cmd_err | input | 1 | Protocol engine reports failure |
| slot_active | output | 31 | Per-slot active status |
| irq_status | output | 2 | Bit 0 completion, bit 1 error |
| irq_clr_we | input | 1 | Write-one-to-clear strobe |
| irq_clr_mask | input | 2 | Flags to clear |
| irq_enable | input | 2 | Per-flag interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:

- **Slot 31 and duplicate submissions.** A design that took them would queue a phantom or doubled command, and its active vector or dispatch order would diverge.
- **Both paths writing in one cycle.** Wrong ordering shows up as a swapped dispatch order.
- **Holding the link busy while the queue fills, then freeing it mid-command.** A design that dispatches without gating, or before the outstanding command ends, emits an early strobe.
- **Done and error together, done while idle, and a write-one-to-clear that collides with a new flag.** These expose a wrong flag choice, spurious status, or a lost interrupt.

// File: rtl/slotdisp_pkg.sv
package slotdisp_pkg;
   typedef enum logic {
      DSP_IDLE = 1'b0,
      DSP_RUN  = 1'b1
   } dsp_state_e;

   localparam int IRQ_W   = 2;
   localparam int IRQ_CMP = 0;
   localparam int IRQ_ERR = 1;
endpackage

// File: rtl/slotdisp_fifo.sv
module slotdisp_fifo #(
   parameter int W     = 5,
   parameter int DEPTH = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_a,
   input  logic [W-1:0] data_a,
   input  logic         push_b,
   input  logic [W-1:0] data_b,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_ptr_b;
   logic [CW-1:0] count;
   logic [CW-1:0] n_push;

   initial begin
      assert (DEPTH >= 2) else $error("slotdisp_fifo: DEPTH must be at least 2");
      assert (W >= 1)     else $error("slotdisp_fifo: W must be positive");
   end

   function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
      return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
   endfunction

   assign wr_ptr_b = push_a ? ptr_inc(wr_ptr) : wr_ptr;
   assign n_push   = CW'(push_a) + CW'(push_b);
   assign empty    = (count == '0);
   assign head     = mem[rd_ptr];

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (push_a && int'(wr_ptr) == i)
            mem[i] <= data_a;
         else if (push_b && int'(wr_ptr_b) == i)
            mem[i] <= data_b;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_b)
            wr_ptr <= ptr_inc(wr_ptr_b);
         else if (push_a)
            wr_ptr <= wr_ptr_b;
         if (pop)
            rd_ptr <= ptr_inc(rd_ptr);
         count <= count + n_push - CW'(pop);
      end
   end

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(count) + int'(n_push) - int'(pop)) <= DEPTH);

   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/slotdisp_track.sv
module slotdisp_track
   import slotdisp_pkg::*;
#(
   parameter int NUM_SLOTS = 31,
   parameter int SLOT_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_a_en,
   input  logic [SLOT_W-1:0]    set_a_slot,
   input  logic                 set_b_en,
   input  logic [SLOT_W-1:0]    set_b_slot,
   input  logic                 clr_en,
   input  logic [SLOT_W-1:0]    clr_slot,
   input  logic                 cmp_set,
   input  logic                 err_set,
   input  logic                 w1c_en,
   input  logic [IRQ_W-1:0]     w1c_mask,
   input  logic [IRQ_W-1:0]     irq_en,
   output logic [NUM_SLOTS-1:0] active,
   output logic [IRQ_W-1:0]     irq_status,
   output logic                 irq
);
   logic [IRQ_W-1:0] set_vec, clr_vec;

   initial begin
      assert (NUM_SLOTS <= (1 << SLOT_W))
         else $error("slotdisp_track: NUM_SLOTS exceeds SLOT_W range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= '0;
      end else begin
         for (int i = 0; i < NUM_SLOTS; i++) begin
            if ((set_a_en && set_a_slot == SLOT_W'(i)) ||
                (set_b_en && set_b_slot == SLOT_W'(i)))
               active[i] <= 1'b1;
            else if (clr_en && clr_slot == SLOT_W'(i))
               active[i] <= 1'b0;
         end
      end
   end

   always_comb begin
      set_vec          = '0;
      set_vec[IRQ_CMP] = cmp_set;
      set_vec[IRQ_ERR] = err_set;
      clr_vec          = w1c_en ? w1c_mask : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_status <= '0;
      else
         irq_status <= (irq_status & ~clr_vec) | set_vec;
   end

   assign irq = |(irq_status & irq_en);

   a_r8_cmp_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_set |=> irq_status[IRQ_CMP]);

   a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> irq_status[IRQ_ERR]);

   a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_en && w1c_mask[IRQ_ERR] && !err_set) |=> !irq_status[IRQ_ERR]);

   a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status[IRQ_CMP] && !(w1c_en && w1c_mask[IRQ_CMP])) |=> irq_status[IRQ_CMP]);
endmodule

// File: rtl/slot_dispatch.sv
module slot_dispatch
   import slotdisp_pkg::*;
#(
   parameter int NUM_SLOTS  = 31,
   parameter int SLOT_W     = 5,
   parameter int QDEPTH     = 32,
   parameter int SLOT_SHIFT = 7,
   parameter int ADDR_W     = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_slot_we,
   input  logic [SLOT_W-1:0]    host_slot_num,
   input  logic                 fetch_slot_we,
   input  logic [SLOT_W-1:0]    fetch_slot_num,
   input  logic                 link_busy,
   output logic                 disp_valid,
   output logic [SLOT_W-1:0]    disp_slot,
   output logic [ADDR_W-1:0]    disp_addr,
   input  logic                 cmd_done,
   input  logic                 cmd_err,
   output logic [NUM_SLOTS-1:0] slot_active,
   output logic [IRQ_W-1:0]     irq_status,
   input  logic                 irq_clr_we,
   input  logic [IRQ_W-1:0]     irq_clr_mask,
   input  logic [IRQ_W-1:0]     irq_enable,
   output logic                 irq
);
   localparam int PAD_W = 1 << SLOT_W;
   localparam int BASE_W = SLOT_W + SLOT_SHIFT;

   dsp_state_e        state;
   logic [SLOT_W-1:0] run_slot;
   logic [PAD_W-1:0]  act_pad;
   logic              dir_ok, fet_ok;
   logic              q_empty, start, fin;
   logic [SLOT_W-1:0] q_head;

   initial begin
      assert (QDEPTH >= NUM_SLOTS)
         else $error("slot_dispatch: QDEPTH must hold every slot");
      assert (NUM_SLOTS < PAD_W)
         else $error("slot_dispatch: one slot code must stay reserved");
      assert (ADDR_W >= BASE_W)
         else $error("slot_dispatch: ADDR_W too narrow for slot base");
   end

   assign act_pad = PAD_W'(slot_active);

   // Submission filter: valid number, not active, not a same-cycle duplicate.
   assign dir_ok = host_slot_we && (int'(host_slot_num) < NUM_SLOTS) &&
                   !act_pad[host_slot_num];
   assign fet_ok = fetch_slot_we && (int'(fetch_slot_num) < NUM_SLOTS) &&
                   !act_pad[fetch_slot_num] &&
                   !(dir_ok && fetch_slot_num == host_slot_num);

   assign start = (state == DSP_IDLE) && !link_busy && !q_empty;
   assign fin   = (state == DSP_RUN) && (cmd_done || cmd_err);

   slotdisp_fifo #(.W(SLOT_W), .DEPTH(QDEPTH)) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_a (dir_ok),
      .data_a (host_slot_num),
      .push_b (fet_ok),
      .data_b (fetch_slot_num),
      .pop    (start),
      .head   (q_head),
      .empty  (q_empty)
   );

   slotdisp_track #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_a_en   (dir_ok),
      .set_a_slot (host_slot_num),
      .set_b_en   (fet_ok),
      .set_b_slot (fetch_slot_num),
      .clr_en     (fin),
      .clr_slot   (run_slot),
      .cmp_set    (fin && !cmd_err),
      .err_set    (fin && cmd_err),
      .w1c_en     (irq_clr_we),
      .w1c_mask   (irq_clr_mask),
      .irq_en     (irq_enable),
      .active     (slot_active),
      .irq_status (irq_status),
      .irq        (irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= DSP_IDLE;
         run_slot   <= '0;
         disp_valid <= 1'b0;
      end else begin
         disp_valid <= start;
         if (start) begin
            state    <= DSP_RUN;
            run_slot <= q_head;
         end else if (fin) begin
            state <= DSP_IDLE;
         end
      end
   end

   assign disp_slot = run_slot;

   generate
      if (SLOT_SHIFT == 0) begin : g_base_flat
         assign disp_addr = ADDR_W'(run_slot);
      end else begin : g_base_shift
         logic [BASE_W-1:0] base;
         assign base      = {run_slot, {SLOT_SHIFT{1'b0}}};
         assign disp_addr = ADDR_W'(base);
      end
   endgenerate

   a_r5_link_gate: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> $past(!link_busy));

   a_r2_dispatched_active: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> act_pad[disp_slot]);

   a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |=> !disp_valid);

   a_r8_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !act_pad[$past(run_slot)]);

   a_r4_ignore_top_code: assert property (@(posedge clk) disable iff (!rst_n)
      (host_slot_we && (&host_slot_num) && !fetch_slot_we && !fin) |=> $stable(slot_active));
endmodule

// File: tb/slot_dispatch_bench.sv
module slot_dispatch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_slot_we = 0, fetch_slot_we = 0, link_busy = 0;
   logic [4:0]  host_slot_num = 0, fetch_slot_num = 0;
   logic        cmd_done = 0, cmd_err = 0, irq_clr_we = 0;
   logic [1:0]  irq_clr_mask = 0, irq_enable = 0;
   logic        disp_valid, irq;
   logic [4:0]  disp_slot;
   logic [11:0] disp_addr;
   logic [30:0] slot_active;
   logic [1:0]  irq_status;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   int      mq[$];
   bit [30:0] m_act;
   bit [1:0]  m_irq;
   bit        m_busy, m_dv;
   int        m_ds, m_en;

   always #10 clk = ~clk;

   slot_dispatch u_slot_dispatch (
      .clk(clk), .rst_n(rst_n),
      .host_slot_we(host_slot_we), .host_slot_num(host_slot_num),
      .fetch_slot_we(fetch_slot_we), .fetch_slot_num(fetch_slot_num),
      .link_busy(link_busy),
      .disp_valid(disp_valid), .disp_slot(disp_slot), .disp_addr(disp_addr),
      .cmd_done(cmd_done), .cmd_err(cmd_err),
      .slot_active(slot_active), .irq_status(irq_status),
      .irq_clr_we(irq_clr_we), .irq_clr_mask(irq_clr_mask),
      .irq_enable(irq_enable), .irq(irq)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int exp_irq(bit [1:0] st, int en);
      return ((st & en[1:0]) != 0) ? 1 : 0;
   endfunction

   task automatic check_all();
      chk("R5 disp_valid", int'(disp_valid), int'(m_dv));
      if (m_dv) begin
         chk("R5 disp_slot order", int'(disp_slot), m_ds);
         chk("R6 disp_addr", int'(disp_addr), m_ds * 128);
      end
      chk("R8 slot_active", int'(slot_active), int'(m_act));
      chk("R9 irq_status", int'(irq_status), int'(m_irq));
      chk("R10 irq", int'(irq), exp_irq(m_irq, m_en));
   endtask

   // One clock: drive inputs, advance the model per the requirements, check.
   task automatic step(bit hw, int hs, bit fw, int fs, bit lb,
                       bit dn, bit er, bit cw, int cm, int en);
      bit acc_d, acc_f;
      bit [30:0] act0;
      bit [1:0] setv;
      host_slot_we = hw; host_slot_num = 5'(hs);
      fetch_slot_we = fw; fetch_slot_num = 5'(fs);
      link_busy = lb; cmd_done = dn; cmd_err = er;
      irq_clr_we = cw; irq_clr_mask = 2'(cm); irq_enable = 2'(en);
      act0 = m_act;
      setv = 0;
      m_dv = 0;
      if (m_busy && (dn || er)) begin
         m_act[m_ds] = 0;
         if (er) setv[1] = 1; else setv[0] = 1;
      end
      acc_d = hw && hs < 31 && !act0[hs % 31];
      acc_f = fw && fs < 31 && !act0[fs % 31] && !(acc_d && fs == hs);
      if (!m_busy && !lb && mq.size() > 0) begin
         m_dv = 1;
         m_ds = mq.pop_front();
      end
      if (m_dv) m_busy = 1;
      else if (m_busy && (dn || er)) m_busy = 0;
      if (acc_d) begin mq.push_back(hs); m_act[hs] = 1; end
      if (acc_f) begin mq.push_back(fs); m_act[fs] = 1; end
      m_irq = (m_irq & ~(cw ? 2'(cm) : 2'b00)) | setv;
      m_en = en;
      @(negedge clk);
      check_all();
   endtask

   task automatic idle(int n, bit lb);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, lb, 0, 0, 0, 0, m_en);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      m_act = 0; m_irq = 0; m_busy = 0; m_dv = 0; m_ds = 0; m_en = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 slot_active", int'(slot_active), 0);
      chk("R1 irq_status", int'(irq_status), 0);
      chk("R1 disp_valid", int'(disp_valid), 0);
      chk("R1 irq", int'(irq), 0);

      // R2 direct submission while the link is busy
      step(1, 3, 0, 0, 1, 0, 0, 0, 0, 3);
      chk("R2 slot 3 active", int'(slot_active[3]), 1);
      // R4 slot 31 from both paths ignored
      step(1, 31, 1, 31, 1, 0, 0, 0, 0, 3);
      chk("R4 code 31 ignored", int'(slot_active), 32'h8);
      // R3 both paths in one cycle; R4 duplicate of active slot 3 ignored
      step(1, 5, 1, 7, 1, 0, 0, 0, 0, 3);
      step(1, 3, 1, 9, 1, 0, 0, 0, 0, 3);
      step(1, 12, 1, 12, 1, 0, 0, 0, 0, 3);
      chk("R3 both paths active", int'(slot_active), 32'h12A8);
      idle(3, 1);
      chk("R5 held while link busy", int'(disp_valid), 0);
      // release link: slot 3 first
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
      chk("R5 first dispatch", int'(disp_slot), 3);
      idle(3, 0);
      chk("R7 no second dispatch while busy", int'(disp_valid), 0);
      step(0, 0, 0, 0, 0, 1, 0, 0, 0, 3);
      chk("R8 completion flag", int'(irq_status), 1);
      chk("R10 irq on completion", int'(irq), 1);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
      chk("R3 direct ahead of fetch", int'(disp_slot), 5);
      // R8 done and err together: error wins
      step(0, 0, 0, 0, 0, 1, 1, 0, 0, 3);
      chk("R8 error flag", int'(irq_status), 3);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
      chk("R3 fetched slot next", int'(disp_slot), 7);
      // R9 clear completion while error flag is set again in the same cycle
      step(0, 0, 0, 0, 1, 0, 1, 1, 3, 3);
      chk("R9 set wins over clear", int'(irq_status), 2);
      // R10 enable masks
      idle(1, 1);
      step(0, 0, 0, 0, 1, 0, 0, 0, 0, 1);
      chk("R10 masked error", int'(irq), 0);
      step(0, 0, 0, 0, 1, 0, 0, 1, 2, 2);
      chk("R9 error cleared", int'(irq_status), 0);
      // R8 done while idle ignored
      step(0, 0, 0, 0, 1, 1, 1, 0, 0, 3);
      chk("R8 ignored when idle", int'(irq_status), 0);

      // constrained random phase
      for (int i = 0; i < 4000; i++) begin
         step($urandom % 10 < 3, $urandom % 32,
              $urandom % 10 < 3, $urandom % 32,
              $urandom % 10 < 3,
              $urandom % 4 == 0, $urandom % 9 == 0,
              $urandom % 8 == 0, $urandom % 4,
              ($urandom % 16 == 0) ? $urandom % 4 : m_en);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule